// File: doc/BRIEF.md
# Packed Fixed-Point SIMD Execution Unit with Accumulator

The unit runs packed fixed-point arithmetic on 64-bit operands. An operand can be split into two 32-bit lanes or into four 16-bit lanes. In this description the upper lane is `[63:32]` (the most significant word) and the lower lane is `[31:0]`. The unit does lane-wise addition, both wrapping and saturating, and lane-wise compares. A scalar add works on the lower word only. A multiply-accumulate writes into a persistent 64-bit accumulator. Each operation is presented for one cycle with `in_valid`, and its result appears one cycle later.

The accumulator is written on the same clock edge that registers the result. A MAC issued in the very next cycle therefore reads the value just produced, so a chain of dependent MACs retires one per cycle with no stall. Overflow and saturation events are collected in a sticky four-bit status word. Software clears bits by writing zeros through `stat_wr`/`stat_wdata`.

A three-state controller tracks what retired last:
- `ST_IDLE`: nothing retired.
- `ST_EXEC`: a non-MAC operation retired.
- `ST_CHAIN`: a MAC retired and the accumulator was just written.

The transitions are:
- Any state moves to `ST_IDLE` when `in_valid` is low.
- Any state moves to `ST_CHAIN` on a valid MAC.
- Any state moves to `ST_EXEC` on any other valid operation.

`out_valid` is high in `ST_EXEC` and `ST_CHAIN`.

Top module: `simd_mac_unit`

## Requirements
- R1: After reset `out_valid`, `out_result`, `cmp_flags`, `status` and the accumulator are all zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: Opcode 0 (vector add) returns each 32-bit lane as the wrapped sum of the matching lanes. It sets `status[3]` when the upper lane has signed overflow and `status[2]` when the lower lane has signed overflow.
- R4: Opcode 1 (saturating vector add) clamps each 32-bit lane to 0x7FFFFFFF or 0x80000000 on signed overflow. It sets `status[1]` when the upper lane saturates and `status[0]` when the lower lane saturates.
- R5: Opcode 2 adds four 16-bit lanes with wraparound. No carry crosses a 16-bit boundary, and no status bit changes.
- R6: Opcode 5 (scalar add) returns the wrapped sum of the lower words in `[31:0]` and passes `op_a[63:32]` through unchanged. It sets `status[2]` on signed overflow.
- R7: Opcode 3 (signed greater-than, a > b) and opcode 4 (equal) write `cmp_flags = {upper true, lower true, either true, both true}` and leave `out_result` unchanged. Other opcodes leave `cmp_flags` unchanged.
- R8: Opcode 7 loads the accumulator from `op_a` and returns `op_a`.
- R9: Opcode 6 (vector MAC) multiplies, per 32-bit lane, the signed low 16-bit halves of a and b. It adds the product, with wraparound, into the matching 32-bit half of the accumulator and returns the new accumulator. Back-to-back MACs each see the previous MAC's accumulator.
- R10: Status bits are sticky. A cycle with `stat_wr` high ANDs the status with `stat_wdata`. A bit set by the operation retiring in that same cycle still ends up set.
- R11: Opcodes 2, 3, 4, 6 and 7 never change `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Opcode |
| op_a | input | 64 | Operand a |
| op_b | input | 64 | Operand b |
| stat_wr | input | 1 | Status clear strobe |
| stat_wdata | input | 4 | AND mask applied to status on `stat_wr` |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Result register |
| cmp_flags | output | 4 | Compare condition nibble |
| status | output | 4 | Sticky {ovf_hi, ovf_lo, sat_hi, sat_lo} |

## Verification
The bench targets the following corner cases, and what a design that got each wrong would do:
- **Signed overflow in each lane direction.** A design that detects unsigned carry instead would flag the wrong lanes. A design that clamps by the result's sign would saturate to the wrong extreme.
- **16-bit adds whose carry would leak across boundaries.** A design that leaks carry shows a nonzero upper halfword.
- **Scalar add with a distinctive upper word.** A design that clobbers `[63:32]` is caught.
- **Chains of back-to-back MACs with negative products.** A design that reads a stale accumulator, or zero-extends the halves, produces a wrong running sum.
- **A status clear in the same cycle as a new overflow.** This exposes a design that lets the clear win over the new set.
- **Compares followed by the result port.** This exposes a compare that overwrites `out_result`.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;
    localparam int HALF_W  = 16;
    localparam int LANE_W  = 2 * HALF_W;
    localparam int N_LANES = 2;
    localparam int DATA_W  = N_LANES * LANE_W;
    localparam int STAT_W  = 2 * N_LANES;

    typedef enum logic [2:0] {
        OP_ADDV  = 3'd0,
        OP_ADDSV = 3'd1,
        OP_ADDH  = 3'd2,
        OP_CMPGT = 3'd3,
        OP_CMPEQ = 3'd4,
        OP_ADDS  = 3'd5,
        OP_MACV  = 3'd6,
        OP_LDACC = 3'd7
    } simd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXEC  = 2'd1,
        ST_CHAIN = 2'd2
    } simd_st_e;
endpackage

// File: rtl/simd_lane_add.sv
module simd_lane_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum_wrap,
    output logic [W-1:0] sum_sat,
    output logic [W-1:0] sum_half,
    output logic         ovf,
    output logic         gt,
    output logic         eq
);
    localparam int H = W / 2;

    logic [W:0] ext_sum;

    assign ext_sum  = {a[W-1], a} + {b[W-1], b};
    assign sum_wrap = ext_sum[W-1:0];
    assign ovf      = ext_sum[W] ^ ext_sum[W-1];

    // clamp direction follows the operand sign, which both operands share on overflow
    assign sum_sat  = !ovf    ? ext_sum[W-1:0] :
                      a[W-1]  ? {1'b1, {(W-1){1'b0}}} :
                                {1'b0, {(W-1){1'b1}}};

    assign sum_half = {a[W-1:H] + b[W-1:H], a[H-1:0] + b[H-1:0]};
    assign gt       = $signed(a) > $signed(b);
    assign eq       = (a == b);
endmodule

// File: rtl/simd_lane_mac.sv
module simd_lane_mac #(
    parameter int H = 16
) (
    input  logic [H-1:0]   a,
    input  logic [H-1:0]   b,
    input  logic [2*H-1:0] acc,
    output logic [2*H-1:0] acc_next
);
    logic [2*H-1:0] a_ext;
    logic [2*H-1:0] b_ext;
    logic [2*H-1:0] prod;

    assign a_ext    = {{H{a[H-1]}}, a};
    assign b_ext    = {{H{b[H-1]}}, b};
    assign prod     = a_ext * b_ext;
    assign acc_next = acc + prod;
endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
    import simd_mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [3:0]        cmp_flags,
    output logic [STAT_W-1:0] status
);
    simd_op_e          op;
    simd_st_e          st_q, st_d;

    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] lane_wrap, lane_sat, lane_half, mac_acc;
    logic [N_LANES-1:0] lane_ovf, lane_gt, lane_eq;

    logic [DATA_W-1:0] res_d, acc_d;
    logic [3:0]        flags_d;
    logic [STAT_W-1:0] stat_set;
    logic              upd_res, upd_acc, upd_flags;

    assign op = simd_op_e'(in_op);

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        simd_lane_add #(.W(LANE_W)) u_add (
            .a        (op_a[g*LANE_W +: LANE_W]),
            .b        (op_b[g*LANE_W +: LANE_W]),
            .sum_wrap (lane_wrap[g*LANE_W +: LANE_W]),
            .sum_sat  (lane_sat[g*LANE_W +: LANE_W]),
            .sum_half (lane_half[g*LANE_W +: LANE_W]),
            .ovf      (lane_ovf[g]),
            .gt       (lane_gt[g]),
            .eq       (lane_eq[g])
        );
        simd_lane_mac #(.H(HALF_W)) u_mac (
            .a        (op_a[g*LANE_W +: HALF_W]),
            .b        (op_b[g*LANE_W +: HALF_W]),
            .acc      (acc_q[g*LANE_W +: LANE_W]),
            .acc_next (mac_acc[g*LANE_W +: LANE_W])
        );
    end

    // operation select: what each opcode writes and which sticky bits it raises
    always_comb begin
        res_d     = out_result;
        acc_d     = acc_q;
        flags_d   = cmp_flags;
        stat_set  = '0;
        upd_res   = 1'b0;
        upd_acc   = 1'b0;
        upd_flags = 1'b0;
        unique case (op)
            OP_ADDV: begin
                res_d          = lane_wrap;
                upd_res        = 1'b1;
                stat_set[3:2]  = lane_ovf;
            end
            OP_ADDSV: begin
                res_d          = lane_sat;
                upd_res        = 1'b1;
                stat_set[1:0]  = lane_ovf;
            end
            OP_ADDH: begin
                res_d          = lane_half;
                upd_res        = 1'b1;
            end
            OP_CMPGT: begin
                flags_d   = {lane_gt[1], lane_gt[0], |lane_gt, &lane_gt};
                upd_flags = 1'b1;
            end
            OP_CMPEQ: begin
                flags_d   = {lane_eq[1], lane_eq[0], |lane_eq, &lane_eq};
                upd_flags = 1'b1;
            end
            OP_ADDS: begin
                res_d       = {op_a[DATA_W-1:LANE_W], lane_wrap[LANE_W-1:0]};
                upd_res     = 1'b1;
                stat_set[2] = lane_ovf[0];
            end
            OP_MACV: begin
                res_d   = mac_acc;
                acc_d   = mac_acc;
                upd_res = 1'b1;
                upd_acc = 1'b1;
            end
            OP_LDACC: begin
                res_d   = op_a;
                acc_d   = op_a;
                upd_res = 1'b1;
                upd_acc = 1'b1;
            end
        endcase
    end

    // next-state of the retire tracker
    always_comb begin
        if (!in_valid)           st_d = ST_IDLE;
        else if (op == OP_MACV)  st_d = ST_CHAIN;
        else                     st_d = ST_EXEC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs and architectural state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result <= '0;
            acc_q      <= '0;
            cmp_flags  <= '0;
            status     <= '0;
        end else begin
            if (in_valid && upd_res)   out_result <= res_d;
            if (in_valid && upd_acc)   acc_q      <= acc_d;
            if (in_valid && upd_flags) cmp_flags  <= flags_d;
            status <= (stat_wr ? (status & stat_wdata) : status)
                      | (in_valid ? stat_set : '0);
        end
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE:  out_valid = 1'b0;
            ST_EXEC:  out_valid = 1'b1;
            ST_CHAIN: out_valid = 1'b1;
            default:  out_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/simd_mac_unit_chk.sv
module simd_mac_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [2:0]  in_op,
    input logic [63:0] op_a,
    input logic        stat_wr,
    input logic        out_valid,
    input logic [63:0] out_result,
    input logic [3:0]  cmp_flags,
    input logic [3:0]  status
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_FLAGS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flags[1] == (cmp_flags[3] | cmp_flags[2])) &&
        (cmp_flags[0] == (cmp_flags[3] & cmp_flags[2]))); // R7
    AST_CMP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 3'd3 || in_op == 3'd4)) |=> $stable(out_result)); // R7
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && (in_op == 3'd3 || in_op == 3'd4)) |=> $stable(cmp_flags)); // R7
    AST_LOAD_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd7) |=> (out_result == $past(op_a))); // R8
    AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((status & $past(status)) == $past(status))); // R10
    AST_QUIET_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_wr && in_valid && (in_op == 3'd2 || in_op == 3'd3 || in_op == 3'd4 ||
                                  in_op == 3'd6 || in_op == 3'd7)) |=> $stable(status)); // R11
endmodule

bind simd_mac_unit simd_mac_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .op_a       (op_a),
    .stat_wr    (stat_wr),
    .out_valid  (out_valid),
    .out_result (out_result),
    .cmp_flags  (cmp_flags),
    .status     (status)
);

// File: tb/simd_mac_unit_bench.sv
module simd_mac_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        stat_wr = 1'b0;
    logic [3:0]  stat_wdata = 4'hF;
    logic        out_valid;
    logic [63:0] out_result;
    logic [3:0]  cmp_flags;
    logic [3:0]  status;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    simd_mac_unit u_simd_mac_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .op_a(op_a), .op_b(op_b), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .out_valid(out_valid), .out_result(out_result),
        .cmp_flags(cmp_flags), .status(status)
    );

    typedef struct {
        logic [63:0] res;
        logic [3:0]  flg;
        logic [3:0]  st;
        string       req;
    } exp_t;
    exp_t sb[$];

    // reference state, built from the requirements
    logic [63:0] m_acc = '0, m_res = '0;
    logic [3:0]  m_flg = '0, m_st = '0;

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3, 3'd4: return "R7";
            3'd5: return "R6";
            3'd6: return "R9";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [32:0] sadd(input logic [31:0] x, input logic [31:0] y);
        longint s;
        s = longint'($signed(x)) + longint'($signed(y));
        return {(s > 64'sd2147483647) || (s < -64'sd2147483648), s[31:0]};
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic wr, input logic [3:0] wd);
        logic [3:0] set;
        logic [32:0] s;
        logic [63:0] r;
        set = '0;
        r = m_res;
        for (int l = 0; l < 2; l++) begin
            s = sadd(a[l*32 +: 32], b[l*32 +: 32]);
            case (op)
                3'd0: begin r[l*32 +: 32] = s[31:0]; set[2+l] = s[32]; end
                3'd1: begin
                    r[l*32 +: 32] = !s[32] ? s[31:0] : (a[l*32+31] ? 32'h8000_0000 : 32'h7FFF_FFFF);
                    set[l] = s[32];
                end
                3'd2: begin
                    r[l*32 +: 16]      = a[l*32 +: 16] + b[l*32 +: 16];
                    r[l*32+16 +: 16]   = a[l*32+16 +: 16] + b[l*32+16 +: 16];
                end
                3'd6: begin
                    int p;
                    p = int'($signed(a[l*32 +: 16])) * int'($signed(b[l*32 +: 16]));
                    m_acc[l*32 +: 32] = m_acc[l*32 +: 32] + p;
                end
                default: ;
            endcase
        end
        case (op)
            3'd3: m_flg = {$signed(a[63:32]) > $signed(b[63:32]), $signed(a[31:0]) > $signed(b[31:0]), 2'b00};
            3'd4: m_flg = {a[63:32] == b[63:32], a[31:0] == b[31:0], 2'b00};
            3'd5: begin s = sadd(a[31:0], b[31:0]); r = {a[63:32], s[31:0]}; set[2] = s[32]; end
            3'd6: r = m_acc;
            3'd7: begin m_acc = a; r = a; end
            default: ;
        endcase
        if (op == 3'd3 || op == 3'd4) m_flg[1:0] = {m_flg[3] | m_flg[2], m_flg[3] & m_flg[2]};
        m_res = r;
        if (wr) m_st = m_st & wd;
        m_st = m_st | set;
    endtask

    task automatic issue(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic wr = 1'b0, input logic [3:0] wd = 4'hF);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; op_a = a; op_b = b; stat_wr = wr; stat_wdata = wd;
        model(op, a, b, wr, wd);
        e.res = m_res; e.flg = m_flg; e.st = m_st;
        e.req = wr ? "R10" : req_of(op);
        sb.push_back(e);
    endtask

    task automatic idle(input logic wr = 1'b0, input logic [3:0] wd = 4'hF);
        @(negedge clk);
        in_valid = 1'b0; stat_wr = wr; stat_wdata = wd;
        if (wr) m_st = m_st & wd;
        @(negedge clk);
        stat_wr = 1'b0;
        check("R2", "out_valid after idle", {63'd0, out_valid}, 64'd0);
        check(wr ? "R10" : "R11", "status after idle", {60'd0, status}, {60'd0, m_st});
    endtask

    // monitor: pops one expected item per valid result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL R2 unexpected out_valid actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "result", out_result, e.res);
                check(e.req, "flags", {60'd0, cmp_flags}, {60'd0, e.flg});
                check(e.req == "R7" || e.req == "R10" ? e.req : "R11", "status",
                      {60'd0, status}, {60'd0, e.st});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid", {63'd0, out_valid}, 64'd0);
        check("R1", "result", out_result, 64'd0);
        check("R1", "flags", {60'd0, cmp_flags}, 64'd0);
        check("R1", "status", {60'd0, status}, 64'd0);

        // R3: upper lane positive overflow, lower lane plain
        issue(3'd0, {32'h7FFF_FFFF, 32'h0000_0005}, {32'h0000_0001, 32'h0000_0003});
        // R3: lower lane negative overflow
        issue(3'd0, {32'h0000_0010, 32'h8000_0000}, {32'h0000_0020, 32'hFFFF_FFFF});
        idle(1'b1, 4'h0);   // R10: clear all
        // R4: saturate high and low
        issue(3'd1, {32'h7FFF_FFF0, 32'h8000_0010}, {32'h0000_0100, 32'hFFFF_FF00});
        issue(3'd1, {32'h0000_0002, 32'hFFFF_FFFE}, {32'h0000_0003, 32'h0000_0001});
        // R5: no carry across 16-bit boundaries
        issue(3'd2, 64'h7FFF_FFFF_0001_8000, 64'h0001_0001_FFFF_8000);
        // R7: compares
        issue(3'd3, {32'h0000_0005, 32'hFFFF_FFFF}, {32'h0000_0003, 32'h0000_0000});
        issue(3'd4, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0);
        issue(3'd3, {32'h8000_0000, 32'h0000_0001}, {32'h7FFF_FFFF, 32'h0000_0002});
        // R6: scalar add keeps upper word
        issue(3'd5, {32'hDEAD_BEEF, 32'h7FFF_FFFF}, {32'h1111_1111, 32'h0000_0001});
        // R10: clear ovf_lo while a new upper overflow is raised in the same cycle
        issue(3'd0, {32'h7FFF_FFFF, 32'h0}, {32'h7FFF_FFFF, 32'h0}, 1'b1, 4'b0011);
        // R8 then R9 back-to-back chain with negative products
        issue(3'd7, {32'h0000_0100, 32'hFFFF_FFF0}, 64'd0);
        issue(3'd6, {32'h0000_0003, 32'h0000_FFFE}, {32'h0000_0004, 32'h0000_0005});
        issue(3'd6, {32'h0000_8000, 32'h0000_7FFF}, {32'h0000_8000, 32'h0000_8000});
        issue(3'd6, {32'hABCD_FFFF, 32'h1234_0002}, {32'h5555_FFFF, 32'h9999_FFFD});
        idle();
        issue(3'd6, 64'h0000_0007_0000_0009, 64'h0000_0002_0000_0003);
        // mixed stream through the reference model
        for (int i = 0; i < 60; i++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (i % 7 == 0) b = a;
            issue(3'($urandom_range(0, 7)), a, b, (i % 11 == 5), 4'($urandom));
        end
        idle();
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL R2 missing results actual=%0d expected=0", sb.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule